// File: doc/BRIEF.md
# Processor interrupt entry sequencer

This block sits beside the execute stage of a small processor core and decides, at each instruction boundary, whether the core must leave its normal flow to service an interrupt. It accepts a level-sensitive maskable request line, an edge-triggered non-maskable line, exception strobes from the execute stage (divide error, undefined opcode, escape opcode), a breakpoint request and a general software interrupt request with its own 8-bit type number. It also owns the core's 16-bit flags word, whose interrupt-enable bit (IF, bit 9) and trap bit (TF, bit 8) gate two of the sources.

When a source wins, the sequencer holds the core busy. For a maskable request it first runs a one-cycle bus acknowledge and reads the type byte from the data bus. It then issues three push commands, clears IF and TF, and finishes with a one-cycle done strobe carrying the 10-bit vector-table address. A return command from the core makes the block issue a pop command and reload the flags word from the stack read data.

Top module: `irq_entry_seq`

## Requirements
- R1: A request starts an entry only in a cycle where `boundary_i` is 1 and the block is idle (`busy_o` = 0). With `boundary_i` at 0 no source starts an entry.
- R2: The maskable request `intr_i` is ignored while IF (flags bit 9) is 0: no acknowledge and no entry follow. The non-maskable input is serviced whatever the flags hold.
- R3: When several sources are present at one boundary, the winner is chosen in this order, highest first: divide error, undefined opcode, escape opcode, breakpoint, general software interrupt, pending non-maskable, maskable (IF=1), single-step (TF=1).
- R4: A rising edge on `nmi_i` is held pending until serviced; each rising edge produces exactly one entry, with type 2 (vector address 0x008).
- R5: A maskable entry asserts `inta_o` for exactly one cycle, one cycle after the accepting boundary; the byte on `bus_data_i` in that cycle becomes the type. No other source asserts `inta_o`.
- R6: Every entry issues `push_o` for three consecutive cycles carrying, in order, the flags word as it stood when the entry began, `cs_i`, then `ip_i`.
- R7: After the flags push, IF and TF both read 0 in `flags_o`; every other flag bit keeps its value.
- R8: After the last push, `done_o` is 1 for exactly one cycle with `vec_addr_o` equal to the type times four (10 bits); the block is idle in the next cycle.
- R9: TF (flags bit 8) equal to 1 at a boundary with no other source gives a single-step entry of type 1 (vector 0x004).
- R10: Fixed types: divide error 0, single-step 1, non-maskable 2, breakpoint 3, undefined opcode 6, escape opcode 7. The general software interrupt uses `swi_type_i`, any value 0 to 255.
- R11: `iret_i` at an idle cycle with no entry starting gives one cycle of `pop_o`; at the end of that cycle `flags_o` takes the value of `stack_rdata_i`, so IF and TF return to their saved state.
- R12: A flags write from the core (`flags_wr_i`) takes effect only while the block is idle; writes during an entry are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| exc_div_i | input | 1 | Divide error strobe |
| exc_undef_i | input | 1 | Undefined opcode strobe |
| exc_esc_i | input | 1 | Escape opcode strobe |
| brk_i | input | 1 | Breakpoint request |
| swi_i | input | 1 | General software interrupt request |
| swi_type_i | input | 8 | Type for the general software interrupt |
| bus_data_i | input | 8 | Data bus byte read during acknowledge |
| cs_i | input | 16 | Current code segment, pushed second |
| ip_i | input | 16 | Return offset, pushed third |
| flags_wr_i | input | 1 | Core writes the flags word |
| flags_wdata_i | input | 16 | Flags write data |
| iret_i | input | 1 | Return-from-interrupt command |
| stack_rdata_i | input | 16 | Stack read data during pop |
| inta_o | output | 1 | Interrupt acknowledge |
| push_o | output | 1 | Push command |
| push_data_o | output | 16 | Word to push |
| pop_o | output | 1 | Pop command |
| done_o | output | 1 | Entry complete strobe |
| vec_addr_o | output | 10 | Vector-table byte address |
| busy_o | output | 1 | Entry or return in progress, core stalls |
| flags_o | output | 16 | Current flags word |

## Verification
The assertions watch, on every cycle, that the acknowledge, push, pop and done commands never overlap, that an acknowledge only follows a boundary taken with IF set and is followed by the flags push, that an entry starts only from a boundary, that IF and TF are clear at done and that a pop reloads the flags from the stack data. Only the bench scenarios show the priority order between simultaneous sources, the fixed type of each source and its vector, the content and order of the three pushed words, the one-service-per-edge behaviour of the non-maskable input, and that flag writes during an entry are dropped.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_DONE,
    S_POP
  } seq_state_e;

  localparam int C_TYPE_DIV   = 0;
  localparam int C_TYPE_STEP  = 1;
  localparam int C_TYPE_NMI   = 2;
  localparam int C_TYPE_BRK   = 3;
  localparam int C_TYPE_UNDEF = 6;
  localparam int C_TYPE_ESC   = 7;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);

  logic nmi_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  // A fresh edge wins over the clear of the request being taken.
  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (rise)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              exc_div_i,
  input  logic              exc_undef_i,
  input  logic              exc_esc_i,
  input  logic              brk_i,
  input  logic              swi_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic              nmi_pend_i,
  input  logic              intr_ok_i,
  input  logic              step_ok_i,
  output logic              win_o,
  output logic              need_ack_o,
  output logic              sel_nmi_o,
  output logic [TYPE_W-1:0] type_o
);

  always_comb begin
    win_o      = 1'b1;
    need_ack_o = 1'b0;
    sel_nmi_o  = 1'b0;
    type_o     = '0;
    if (exc_div_i) begin
      type_o = TYPE_W'(C_TYPE_DIV);
    end else if (exc_undef_i) begin
      type_o = TYPE_W'(C_TYPE_UNDEF);
    end else if (exc_esc_i) begin
      type_o = TYPE_W'(C_TYPE_ESC);
    end else if (brk_i) begin
      type_o = TYPE_W'(C_TYPE_BRK);
    end else if (swi_i) begin
      type_o = swi_type_i;
    end else if (nmi_pend_i) begin
      type_o    = TYPE_W'(C_TYPE_NMI);
      sel_nmi_o = 1'b1;
    end else if (intr_ok_i) begin
      need_ack_o = 1'b1;
    end else if (step_ok_i) begin
      type_o = TYPE_W'(C_TYPE_STEP);
    end else begin
      win_o = 1'b0;
    end
  end

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int WORD_W = 16,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en_i,
  input  logic              pop_en_i,
  input  logic [WORD_W-1:0] pop_data_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] flags_o
);

  logic [WORD_W-1:0] flags_q;
  logic [WORD_W-1:0] flags_d;
  logic              flags_en;

  assign flags_en = clr_en_i | pop_en_i | wr_en_i;

  always_comb begin
    flags_d = flags_q;
    if (clr_en_i) begin
      flags_d[IF_BIT] = 1'b0;
      flags_d[TF_BIT] = 1'b0;
    end else if (pop_en_i) begin
      flags_d = pop_data_i;
    end else if (wr_en_i) begin
      flags_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int WORD_W = 16,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              exc_div_i,
  input  logic              exc_undef_i,
  input  logic              exc_esc_i,
  input  logic              brk_i,
  input  logic              swi_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic [TYPE_W-1:0] bus_data_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic              flags_wr_i,
  input  logic [WORD_W-1:0] flags_wdata_i,
  input  logic              iret_i,
  input  logic [WORD_W-1:0] stack_rdata_i,
  output logic              inta_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              pop_o,
  output logic              done_o,
  output logic [TYPE_W+1:0] vec_addr_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] flags_o
);

  localparam int VEC_W = TYPE_W + 2;

  seq_state_e        state_q, state_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic              type_en;
  logic              idle;
  logic              accept;
  logic              win;
  logic              need_ack;
  logic              sel_nmi;
  logic [TYPE_W-1:0] win_type;
  logic              nmi_pend;
  logic [WORD_W-1:0] flags;

  assign idle   = (state_q == S_IDLE);
  assign accept = idle & boundary_i & win;

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_i  (nmi_i),
    .take_i (accept & sel_nmi),
    .pend_o (nmi_pend)
  );

  irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .exc_div_i   (exc_div_i),
    .exc_undef_i (exc_undef_i),
    .exc_esc_i   (exc_esc_i),
    .brk_i       (brk_i),
    .swi_i       (swi_i),
    .swi_type_i  (swi_type_i),
    .nmi_pend_i  (nmi_pend),
    .intr_ok_i   (intr_i & flags[IF_BIT]),
    .step_ok_i   (flags[TF_BIT]),
    .win_o       (win),
    .need_ack_o  (need_ack),
    .sel_nmi_o   (sel_nmi),
    .type_o      (win_type)
  );

  irq_flags #(.WORD_W(WORD_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en_i   (state_q == S_PUSH_F),
    .pop_en_i   (state_q == S_POP),
    .pop_data_i (stack_rdata_i),
    .wr_en_i    (flags_wr_i & idle),
    .wr_data_i  (flags_wdata_i),
    .flags_o    (flags)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    type_d  = type_q;
    type_en = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          type_d  = win_type;
          type_en = 1'b1;
          state_d = need_ack ? S_ACK : S_PUSH_F;
        end else if (iret_i) begin
          state_d = S_POP;
        end
      end
      S_ACK: begin
        type_d  = bus_data_i;
        type_en = 1'b1;
        state_d = S_PUSH_F;
      end
      S_PUSH_F:  state_d = S_PUSH_CS;
      S_PUSH_CS: state_d = S_PUSH_IP;
      S_PUSH_IP: state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      S_POP:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
    end else if (type_en) begin
      type_q <= type_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_PUSH_F:  push_data_o = flags;
      S_PUSH_CS: push_data_o = cs_i;
      S_PUSH_IP: push_data_o = ip_i;
      default:   push_data_o = '0;
    endcase
  end

  assign inta_o     = (state_q == S_ACK);
  assign push_o     = (state_q == S_PUSH_F) | (state_q == S_PUSH_CS) | (state_q == S_PUSH_IP);
  assign pop_o      = (state_q == S_POP);
  assign done_o     = (state_q == S_DONE);
  assign vec_addr_o = VEC_W'({type_q, 2'b00});
  assign busy_o     = ~idle;
  assign flags_o    = flags;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int TYPE_W = 8,
  parameter int WORD_W = 16,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              inta_o,
  input logic              push_o,
  input logic              pop_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [WORD_W-1:0] flags_o,
  input logic [WORD_W-1:0] stack_rdata_i
);

  assert_one_command_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inta_o, push_o, pop_o, done_o}));

  assert_ack_needs_if_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_o) |-> $past(flags_o[IF_BIT]));

  assert_ack_then_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> (push_o && !inta_o));

  assert_entry_from_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && !pop_o) |-> $past(boundary_i));

  assert_flags_clear_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!flags_o[IF_BIT] && !flags_o[TF_BIT]));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_pop_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (flags_o == $past(stack_rdata_i)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .TYPE_W (TYPE_W),
  .WORD_W (WORD_W),
  .IF_BIT (IF_BIT),
  .TF_BIT (TF_BIT)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .boundary_i    (boundary_i),
  .inta_o        (inta_o),
  .push_o        (push_o),
  .pop_o         (pop_o),
  .done_o        (done_o),
  .busy_o        (busy_o),
  .flags_o       (flags_o),
  .stack_rdata_i (stack_rdata_i)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam int CLK_P = 10;
  localparam logic [15:0] CS_VAL = 16'h1234;
  localparam logic [15:0] IP_VAL = 16'h5678;
  localparam logic [15:0] F_IF = 16'h0200;
  localparam logic [15:0] F_TF = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i, nmi_i, intr_i, exc_div_i, exc_undef_i, exc_esc_i;
  logic        brk_i, swi_i, flags_wr_i, iret_i;
  logic [7:0]  swi_type_i, bus_data_i;
  logic [15:0] cs_i, ip_i, flags_wdata_i, stack_rdata_i;
  logic        inta_o, push_o, pop_o, done_o, busy_o;
  logic [15:0] push_data_o, flags_o;
  logic [9:0]  vec_addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_i(nmi_i), .intr_i(intr_i),
    .exc_div_i(exc_div_i), .exc_undef_i(exc_undef_i), .exc_esc_i(exc_esc_i),
    .brk_i(brk_i), .swi_i(swi_i), .swi_type_i(swi_type_i), .bus_data_i(bus_data_i),
    .cs_i(cs_i), .ip_i(ip_i), .flags_wr_i(flags_wr_i), .flags_wdata_i(flags_wdata_i),
    .iret_i(iret_i), .stack_rdata_i(stack_rdata_i), .inta_o(inta_o), .push_o(push_o),
    .push_data_o(push_data_o), .pop_o(pop_o), .done_o(done_o), .vec_addr_o(vec_addr_o),
    .busy_o(busy_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic clear_strobes();
    boundary_i = 0; exc_div_i = 0; exc_undef_i = 0; exc_esc_i = 0;
    brk_i = 0; swi_i = 0; iret_i = 0; flags_wr_i = 0;
  endtask

  task automatic write_flags(input logic [15:0] v);
    flags_wr_i = 1; flags_wdata_i = v;
    @(negedge clk);
    flags_wr_i = 0;
  endtask

  // Strobes are set by the caller at the current negedge, boundary included.
  task automatic run_entry(output int acks, output int pushes, output logic [15:0] p [3],
                           output bit seen, output logic [9:0] vec, output logic [15:0] flg);
    acks = 0; pushes = 0; seen = 0; vec = '0; flg = '0;
    p[0] = '0; p[1] = '0; p[2] = '0;
    @(negedge clk);
    clear_strobes();
    for (int k = 0; k < 10; k++) begin
      if (inta_o) acks++;
      if (push_o) begin
        if (pushes < 3) p[pushes] = push_data_o;
        pushes++;
      end
      if (done_o) begin
        seen = 1; vec = vec_addr_o; flg = flags_o;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_entry(input string req, input logic [9:0] exp_vec,
                              input int exp_acks, input logic [15:0] exp_flags);
    int acks, pushes; bit seen; logic [9:0] vec; logic [15:0] flg; logic [15:0] p [3];
    run_entry(acks, pushes, p, seen, vec, flg);
    check(seen, {req, " done"}, 32'(seen), 1);
    check(vec == exp_vec, {req, " vector"}, 32'(vec), 32'(exp_vec));
    check(acks == exp_acks, {req, " R5 acknowledge count"}, 32'(acks), 32'(exp_acks));
    check(pushes == 3 && p[0] == exp_flags && p[1] == CS_VAL && p[2] == IP_VAL,
          {req, " R6 push sequence"}, {p[0], 16'(pushes)}, {exp_flags, 16'd3});
    check(flg == (exp_flags & ~(F_IF | F_TF)), {req, " R7 flags after entry"}, 32'(flg),
          32'(exp_flags & ~(F_IF | F_TF)));
    check(!busy_o, {req, " R8 idle after done"}, 32'(busy_o), 0);
  endtask

  task automatic expect_no_entry(input string req);
    int seen_busy = 0; int seen_ack = 0;
    @(negedge clk);
    clear_strobes();
    for (int k = 0; k < 3; k++) begin
      if (busy_o) seen_busy++;
      if (inta_o) seen_ack++;
      @(negedge clk);
    end
    check(seen_busy == 0 && seen_ack == 0, req, 32'(seen_busy + seen_ack), 0);
  endtask

  task automatic t_reset();
    check(!busy_o && !push_o && !done_o && !inta_o && !pop_o, "R1 reset outputs idle",
          {busy_o, push_o, done_o, inta_o, pop_o}, 0);
    check(flags_o == 16'h0, "R2 reset flags clear", 32'(flags_o), 0);
  endtask

  task automatic t_boundary_gate();
    exc_div_i = 1;
    @(negedge clk); @(negedge clk);
    check(!busy_o, "R1 no entry without boundary", 32'(busy_o), 0);
    boundary_i = 1;
    expect_entry("R1 R10 divide error", 10'h000, 0, 16'h0000);
  endtask

  task automatic t_masked_intr();
    write_flags(16'h0000);
    intr_i = 1; boundary_i = 1;
    expect_no_entry("R2 maskable ignored with IF=0");
    intr_i = 0;
  endtask

  task automatic t_intr();
    write_flags(F_IF | 16'h0005);
    intr_i = 1; bus_data_i = 8'h21; boundary_i = 1;
    expect_entry("R5 R8 maskable type from bus", 10'h084, 1, F_IF | 16'h0005);
    intr_i = 0;
    check(flags_o[9] == 0, "R7 IF clear holds off maskable", 32'(flags_o[9]), 0);
  endtask

  task automatic t_nmi();
    write_flags(16'h0000);
    nmi_i = 1; @(negedge clk); nmi_i = 0; @(negedge clk);
    check(!busy_o, "R4 pending edge waits for boundary", 32'(busy_o), 0);
    boundary_i = 1;
    expect_entry("R4 R2 nmi with IF=0", 10'h008, 0, 16'h0000);
    boundary_i = 1;
    expect_no_entry("R4 one service per edge");
  endtask

  task automatic t_nmi_over_intr();
    write_flags(F_IF);
    nmi_i = 1; @(negedge clk); nmi_i = 0;
    intr_i = 1; bus_data_i = 8'h40; boundary_i = 1;
    expect_entry("R3 nmi beats maskable", 10'h008, 0, F_IF);
    write_flags(F_IF);
    boundary_i = 1;
    expect_entry("R3 maskable after nmi", 10'h100, 1, F_IF);
    intr_i = 0;
  endtask

  task automatic t_priority_chain();
    write_flags(F_IF | F_TF);
    nmi_i = 1; @(negedge clk); nmi_i = 0;
    intr_i = 1; bus_data_i = 8'h55;
    exc_div_i = 1; swi_i = 1; swi_type_i = 8'h40; boundary_i = 1;
    expect_entry("R3 exception first", 10'h000, 0, F_IF | F_TF);
    swi_i = 1; swi_type_i = 8'h40; boundary_i = 1;
    expect_entry("R3 software before nmi", 10'h100, 0, 16'h0000);
    boundary_i = 1;
    expect_entry("R3 nmi after software", 10'h008, 0, 16'h0000);
    intr_i = 0;
    write_flags(F_IF | F_TF);
    intr_i = 1; bus_data_i = 8'h08; boundary_i = 1;
    expect_entry("R3 maskable before single-step", 10'h020, 1, F_IF | F_TF);
    intr_i = 0;
  endtask

  task automatic t_single_step();
    write_flags(F_TF | 16'h0080);
    boundary_i = 1;
    expect_entry("R9 single-step", 10'h004, 0, F_TF | 16'h0080);
    boundary_i = 1;
    expect_no_entry("R9 handler not single-stepped");
  endtask

  task automatic t_fixed_types();
    exc_undef_i = 1; exc_esc_i = 1; boundary_i = 1;
    expect_entry("R10 R3 undefined opcode", 10'h018, 0, flags_o);
    exc_esc_i = 1; boundary_i = 1;
    expect_entry("R10 escape opcode", 10'h01C, 0, flags_o);
    brk_i = 1; swi_i = 1; swi_type_i = 8'h10; boundary_i = 1;
    expect_entry("R10 R3 breakpoint", 10'h00C, 0, flags_o);
    swi_i = 1; swi_type_i = 8'hFF; boundary_i = 1;
    expect_entry("R10 R8 software type 255", 10'h3FC, 0, flags_o);
  endtask

  task automatic t_write_while_busy();
    int acks, pushes; bit seen; logic [9:0] vec; logic [15:0] flg; logic [15:0] p [3];
    write_flags(16'h0011);
    swi_i = 1; swi_type_i = 8'h05; boundary_i = 1;
    @(negedge clk);
    clear_strobes();
    flags_wr_i = 1; flags_wdata_i = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    flags_wr_i = 0;
    for (int k = 0; k < 6; k++) if (busy_o) @(negedge clk);
    check(flags_o == 16'h0011, "R12 flag write ignored while busy", 32'(flags_o), 32'h11);
    write_flags(16'h0022);
    check(flags_o == 16'h0022, "R12 flag write taken while idle", 32'(flags_o), 32'h22);
    acks = 0; pushes = 0; seen = 0; vec = '0; flg = '0;
  endtask

  task automatic t_iret();
    write_flags(16'h0000);
    stack_rdata_i = F_IF | F_TF | 16'h0003; iret_i = 1;
    @(negedge clk);
    iret_i = 0;
    check(pop_o && !push_o, "R11 pop command", {pop_o, push_o}, 2'b10);
    @(negedge clk);
    check(flags_o == (F_IF | F_TF | 16'h0003), "R11 flags restored", 32'(flags_o),
          32'(F_IF | F_TF | 16'h0003));
    check(!busy_o, "R11 idle after pop", 32'(busy_o), 0);
    write_flags(16'h0000);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; nmi_i = 0; intr_i = 0; swi_type_i = 0; bus_data_i = 0;
    cs_i = CS_VAL; ip_i = IP_VAL; flags_wdata_i = 0; stack_rdata_i = 0;
    clear_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_boundary_gate();
    t_masked_intr();
    t_intr();
    t_nmi();
    t_nmi_over_intr();
    t_priority_chain();
    t_single_step();
    t_fixed_types();
    t_write_while_busy();
    t_iret();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule